// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a pair of byte-wide configuration ports, one for an index and one for data, placed on a simple I/O bus. Until software writes a fixed four-byte key to the index port, the block holds no register access: data port reads return 0xFF and data port writes do nothing. After the key, software writes a register number to the index port and then reads or writes that register through the data port. Writing the exit code relocks the port.

The low index range holds global registers: a device-select number, a 16-bit identity and a revision. A small set of per-device registers answers at higher indices: an activate flag and a 16-bit base address. The device-select number chooses which device's set responds. Read data is registered. It changes only on a read strobe and holds until the next one.

Top module: `cfg_port_top`

## Requirements
- R1: Writing the bytes 0x87, 0x01, 0x55, 0x55 in that order to the index port (port_sel=0) opens the port, and cfg_open goes high after the edge that takes the last byte.
- R2: While the port is closed, an index byte that breaks the key restarts matching. A mismatching byte equal to 0x87 counts as the first key byte, so 0x87,0x87,0x01,0x55,0x55 opens the port and 0x87,0x01,0x33,0x55,0x55 does not.
- R3: While the port is closed, writes to the data port (port_sel=1) change nothing and cannot open it, index writes do not move the index register, and reads of either port return 0xFF.
- R4: While the port is open, writing 0x02 to the data port with index 0x02 selected closes the port. Any other value written at index 0x02 leaves the port open.
- R5: While the port is open, an index port write loads the index register, and an index port read returns it.
- R6: Index 0x07 is a read/write device-select number, and it chooses which device's registers respond at 0x30, 0x60 and 0x61.
- R7: Index 0x20 returns the high byte of the CHIP_ID parameter and index 0x21 the low byte. Index 0x22 returns the 4-bit CHIP_REV in bits 3:0 with bits 7:4 zero.
- R8: Index 0x30 is each device's activate flag. Bit 0 of the written byte is stored, and a read returns it in bit 0 with the other bits zero.
- R9: Indices 0x60 and 0x61 hold each device's 16-bit base address, high byte at 0x60 and low byte at 0x61. Both can be read and written.
- R10: Unimplemented indices read 0x00 and ignore writes. With a device-select number of NUM_DEV or more, indices 0x30, 0x60 and 0x61 read 0x00 and ignore writes.
- R11: bus_rdata changes only after a clock edge that samples bus_rd high, and it holds its value otherwise.
- R12: Reset closes the port and clears bus_rdata, the index, the device-select number and every device's activate flag and base address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | High while register access is unlocked |

## Verification
Every result arrives one clock edge after its stimulus. cfg_open changes on the edge that takes the final key byte or the exit write. bus_rdata changes on the edge that samples bus_rd. The bench drives each strobe for exactly one cycle starting at a falling edge and samples at the next falling edge, so the register it checks has just taken the new value. Hold and ignore checks sample again after idle or rejected cycles, to confirm that nothing moved in between.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_B3 = 8'h55;

  localparam logic [7:0] IX_CTRL    = 8'h02;
  localparam logic [7:0] IX_DEVSEL  = 8'h07;
  localparam logic [7:0] IX_ID_HI   = 8'h20;
  localparam logic [7:0] IX_ID_LO   = 8'h21;
  localparam logic [7:0] IX_REV     = 8'h22;
  localparam logic [7:0] IX_ENABLE  = 8'h30;
  localparam logic [7:0] IX_ADDR_HI = 8'h60;
  localparam logic [7:0] IX_ADDR_LO = 8'h61;

  localparam logic [7:0] CLOSE_CODE = 8'h02;

  typedef enum logic [2:0] {
    KS_WAIT0, KS_WAIT1, KS_WAIT2, KS_WAIT3, KS_OPEN
  } key_state_e;

  function automatic logic [7:0] key_at(input key_state_e s);
    case (s)
      KS_WAIT0: key_at = KEY_B0;
      KS_WAIT1: key_at = KEY_B1;
      KS_WAIT2: key_at = KEY_B2;
      default:  key_at = KEY_B3;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] cur_idx,
  output logic       open_o
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == KS_OPEN) begin
      if (data_wr && cur_idx == IX_CTRL && wdata == CLOSE_CODE)
        state_d = KS_WAIT0;
    end else if (idx_wr) begin
      if (wdata == key_at(state_q)) begin
        case (state_q)
          KS_WAIT0: state_d = KS_WAIT1;
          KS_WAIT1: state_d = KS_WAIT2;
          KS_WAIT2: state_d = KS_WAIT3;
          default:  state_d = KS_OPEN;
        endcase
      end else if (wdata == KEY_B0) begin
        state_d = KS_WAIT1;
      end else begin
        state_d = KS_WAIT0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_WAIT0;
    else     state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  // R1
  open_after_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(idx_wr && wdata == KEY_B3));

  // R3
  data_never_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_o && !idx_wr) |=> !open_o);

  // R4
  close_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (open_o && data_wr && cur_idx == IX_CTRL && wdata == CLOSE_CODE) |=> !open_o);

endmodule

// File: rtl/cfg_glob_regs.sv
module cfg_glob_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h6C41,
  parameter logic [3:0]  CHIP_REV = 4'h5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       open_i,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx_q,
  output logic [7:0] devsel_q,
  output logic [7:0] glob_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= 8'h00;
      devsel_q <= 8'h00;
    end else if (open_i) begin
      if (idx_wr) idx_q <= wdata;
      if (data_wr && idx_q == IX_DEVSEL) devsel_q <= wdata;
    end
  end

  always_comb begin
    case (idx_q)
      IX_DEVSEL: glob_rdata = devsel_q;
      IX_ID_HI:  glob_rdata = CHIP_ID[15:8];
      IX_ID_LO:  glob_rdata = CHIP_ID[7:0];
      IX_REV:    glob_rdata = {4'h0, CHIP_REV};
      default:   glob_rdata = 8'h00;
    endcase
  end

  // R5
  idx_locked_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !open_i |=> $stable(idx_q));

  // R6
  devsel_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(open_i && data_wr) |=> $stable(devsel_q));

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] devsel,
  input  logic [7:0] wdata,
  output logic [7:0] bank_rdata
);

  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             dev_ok;
  logic [SEL_W-1:0] sel;
  logic [NUM_DEV-1:0] act_q;
  logic [7:0] addr_hi_q [NUM_DEV];
  logic [7:0] addr_lo_q [NUM_DEV];

  assign dev_ok = (int'(devsel) < NUM_DEV);
  assign sel    = devsel[SEL_W-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = wr_en && dev_ok && (int'(sel) == d);

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[d]     <= 1'b0;
        addr_hi_q[d] <= 8'h00;
        addr_lo_q[d] <= 8'h00;
      end else if (hit) begin
        if (idx == IX_ENABLE)  act_q[d]     <= wdata[0];
        if (idx == IX_ADDR_HI) addr_hi_q[d] <= wdata;
        if (idx == IX_ADDR_LO) addr_lo_q[d] <= wdata;
      end
    end

    // R8
    act_write_only_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && idx == IX_ENABLE) |=> $stable(act_q[d]));

    // R10
    unsel_dev_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && dev_ok && int'(sel) == d) |=> $stable(addr_hi_q[d]));
  end

  always_comb begin
    bank_rdata = 8'h00;
    if (dev_ok) begin
      case (idx)
        IX_ENABLE:  bank_rdata = {7'b0, act_q[sel]};
        IX_ADDR_HI: bank_rdata = addr_hi_q[sel];
        IX_ADDR_LO: bank_rdata = addr_lo_q[sel];
        default:    bank_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h6C41,
  parameter logic [3:0]  CHIP_REV = 4'h5,
  parameter int          NUM_DEV  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       port_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cfg_open
);

  logic       idx_wr, data_wr;
  logic [7:0] idx_q, devsel_q, glob_rdata, bank_rdata, rd_next;

  assign idx_wr  = bus_wr && !port_sel;
  assign data_wr = bus_wr &&  port_sel;

  cfg_key_fsm i_key (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .data_wr(data_wr),
    .wdata(bus_wdata), .cur_idx(idx_q), .open_o(cfg_open)
  );

  cfg_glob_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) i_glob (
    .clk(clk), .rst(rst), .open_i(cfg_open), .idx_wr(idx_wr),
    .data_wr(data_wr), .wdata(bus_wdata), .idx_q(idx_q),
    .devsel_q(devsel_q), .glob_rdata(glob_rdata)
  );

  cfg_dev_bank #(.NUM_DEV(NUM_DEV)) i_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_open && data_wr), .idx(idx_q),
    .devsel(devsel_q), .wdata(bus_wdata), .bank_rdata(bank_rdata)
  );

  always_comb begin
    if (!cfg_open)     rd_next = 8'hFF;
    else if (port_sel) rd_next = glob_rdata | bank_rdata;
    else               rd_next = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R3
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !cfg_open) |=> bus_rdata == 8'hFF);

  // R7
  id_hi_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && port_sel && cfg_open && idx_q == IX_ID_HI) |=> bus_rdata == CHIP_ID[15:8]);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!cfg_open && bus_rdata == 8'h00));

endmodule

// File: tb/test_cfg_port_top.sv
module test_cfg_port_top;

  localparam logic [15:0] T_ID  = 16'h6C41;
  localparam logic [3:0]  T_REV = 4'h5;
  localparam int          T_NDEV = 8;

  localparam logic [1:0] WI = 2'd0, WD = 2'd1, RD = 2'd2, RI = 2'd3;

  function automatic logic [21:0] mk(input logic [1:0] op, input logic [7:0] d,
                                     input logic [7:0] e, input logic [3:0] r);
    mk = {op, d, e, r};
  endfunction

  localparam int NV = 59;
  // Requirement tags used in the table: R1 R3 R4 R5 R6 R7 R8 R9 R10
  localparam logic [21:0] VEC [NV] = '{
    mk(WI,8'h87,8'h00,4'd1), mk(WI,8'h01,8'h00,4'd1), mk(WI,8'h55,8'h00,4'd1),
    mk(WI,8'h55,8'h00,4'd1), mk(RI,8'h00,8'h00,4'd5),
    mk(WI,8'h20,8'h00,4'd7), mk(RD,8'h00,8'h6C,4'd7),
    mk(WI,8'h21,8'h00,4'd7), mk(RD,8'h00,8'h41,4'd7),
    mk(WI,8'h22,8'h00,4'd7), mk(RD,8'h00,8'h05,4'd7),
    mk(WI,8'h07,8'h00,4'd6), mk(WD,8'h03,8'h00,4'd6), mk(RD,8'h00,8'h03,4'd6),
    mk(RI,8'h00,8'h07,4'd5),
    mk(WI,8'h30,8'h00,4'd8), mk(WD,8'h01,8'h00,4'd8), mk(RD,8'h00,8'h01,4'd8),
    mk(WI,8'h60,8'h00,4'd9), mk(WD,8'h12,8'h00,4'd9), mk(WI,8'h61,8'h00,4'd9),
    mk(WD,8'h34,8'h00,4'd9), mk(WI,8'h60,8'h00,4'd9), mk(RD,8'h00,8'h12,4'd9),
    mk(WI,8'h61,8'h00,4'd9), mk(RD,8'h00,8'h34,4'd9),
    mk(WI,8'h07,8'h00,4'd6), mk(WD,8'h05,8'h00,4'd6), mk(WI,8'h30,8'h00,4'd8),
    mk(RD,8'h00,8'h00,4'd8), mk(WI,8'h60,8'h00,4'd9), mk(RD,8'h00,8'h00,4'd9),
    mk(WD,8'hAB,8'h00,4'd9), mk(RD,8'h00,8'hAB,4'd9),
    mk(WI,8'h07,8'h00,4'd6), mk(WD,8'h03,8'h00,4'd6), mk(WI,8'h30,8'h00,4'd6),
    mk(RD,8'h00,8'h01,4'd6), mk(WI,8'h61,8'h00,4'd6), mk(RD,8'h00,8'h34,4'd6),
    mk(WI,8'h30,8'h00,4'd8), mk(WD,8'hFE,8'h00,4'd8), mk(RD,8'h00,8'h00,4'd8),
    mk(WI,8'h45,8'h00,4'd10), mk(WD,8'h77,8'h00,4'd10), mk(RD,8'h00,8'h00,4'd10),
    mk(WI,8'h07,8'h00,4'd10), mk(WD,8'h20,8'h00,4'd10), mk(WI,8'h30,8'h00,4'd10),
    mk(WD,8'h01,8'h00,4'd10), mk(RD,8'h00,8'h00,4'd10),
    mk(WI,8'h07,8'h00,4'd6), mk(RD,8'h00,8'h20,4'd6),
    mk(WI,8'h02,8'h00,4'd4), mk(WD,8'h05,8'h00,4'd4), mk(RI,8'h00,8'h02,4'd4),
    mk(WD,8'h02,8'h00,4'd4), mk(RD,8'h00,8'hFF,4'd3), mk(RI,8'h00,8'hFF,4'd3)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, port_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cfg_open;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cfg_port_top #(.CHIP_ID(T_ID), .CHIP_REV(T_REV), .NUM_DEV(T_NDEV)) i_cfg_port_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .port_sel(port_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic op(input logic [1:0] kind, input logic [7:0] d);
    bus_wr    = (kind == WI || kind == WD);
    bus_rd    = (kind == RD || kind == RI);
    port_sel  = (kind == WD || kind == RD);
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic key_seq(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] e);
    op(WI, a); op(WI, b); op(WI, c); op(WI, e);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    check("R12", {7'b0, cfg_open}, 8'h00);
    check("R12", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][21:20], VEC[i][19:12]);
      if (VEC[i][21:20] == RD || VEC[i][21:20] == RI)
        check($sformatf("R%0d", VEC[i][3:0]), bus_rdata, VEC[i][11:4]);
    end

    // R3: key bytes on the data port while closed do not open it
    op(WD, 8'h87); op(WD, 8'h01); op(WD, 8'h55); op(WD, 8'h55);
    check("R3", {7'b0, cfg_open}, 8'h00);

    // R2: repeated 0x87 restarts at step two
    op(WI, 8'h87);
    key_seq(8'h87, 8'h01, 8'h55, 8'h55);
    check("R2", {7'b0, cfg_open}, 8'h01);
    // R3: closed index writes did not move the index register
    op(RI, 8'h00);
    check("R3", bus_rdata, 8'h02);
    // R4: close again
    op(WD, 8'h02);
    check("R4", {7'b0, cfg_open}, 8'h00);

    // R2: broken key does not open
    op(WI, 8'h87); op(WI, 8'h01); op(WI, 8'h33); op(WI, 8'h55); op(WI, 8'h55);
    check("R2", {7'b0, cfg_open}, 8'h00);
    op(WI, 8'h87); op(WI, 8'h01); op(WI, 8'h55);
    key_seq(8'h87, 8'h01, 8'h55, 8'h55);
    check("R2", {7'b0, cfg_open}, 8'h01);
    // R1: open one edge after the final byte, not before
    op(WI, 8'h02); op(WD, 8'h02);
    key_seq(8'h87, 8'h01, 8'h55, 8'h00);
    check("R1", {7'b0, cfg_open}, 8'h00);
    key_seq(8'h87, 8'h01, 8'h55, 8'h55);
    check("R1", {7'b0, cfg_open}, 8'h01);

    // R11: read data holds across writes and idle cycles
    op(WI, 8'h07); op(RD, 8'h00);
    check("R11", bus_rdata, 8'h20);
    op(WD, 8'h04); op(WI, 8'h30); op(WD, 8'h01);
    @(negedge clk); @(negedge clk);
    check("R11", bus_rdata, 8'h20);

    // R12: reset mid-run clears the device registers
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R12", {7'b0, cfg_open}, 8'h00);
    check("R12", bus_rdata, 8'h00);
    key_seq(8'h87, 8'h01, 8'h55, 8'h55);
    op(WI, 8'h07); op(WD, 8'h03); op(WI, 8'h61); op(RD, 8'h00);
    check("R12", bus_rdata, 8'h00);
    op(WI, 8'h07); op(RD, 8'h00);
    check("R12", bus_rdata, 8'h03);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule